// File: doc/BRIEF.md
# Status-Exchange Effective Address Selector

This block works out how the reference address of a status-exchange instruction is formed. One pulse on `start_i` makes it read an instruction word, the context the instruction runs in (ordinary program flow, interrupt entry or trap entry), the two processor mode bits and the current status-word mapping bit. The block latches the selected reference address, its width class, and flags that tell the rest of the pipeline three things: whether an index register may be added, whether indirection is allowed, and whether the address is used as-is (real) or goes through the translation named by the current status words.

When the instruction's indirect bit is set, the block makes one indirect fetch before it finishes. It raises a request that carries the first reference address and its translation flag. It then waits for the memory side to return the indirect word, trims that word to the same width class, and reports completion. Memory access and index-register reads belong to neighbouring logic.

Bit positions below are counted with bit 0 as the most significant bit of the 32-bit word. In this numbering, bit k is `instr_i[31-k]`.

Top module: `sw_xchg_addr_sel`

## Requirements
- R1: In the ordinary context with the address-type bit (bit 10) at 0, the reference address is bits 12-31 (20 bits), `wide_o`=1, `idx_ok_o`=0 and `mapped_o`=0 (real).
- R2: In the ordinary context with bit 10 at 1, the reference address is bits 15-31 (17 bits, zero-extended), `wide_o`=0, `idx_ok_o`=1 and `mapped_o`=1, whatever the mode bits are.
- R3: In interrupt (`ctx_i`=1) or trap (`ctx_i`=2) context with `ma_i`=1 and `mm_i`=0 (extended addressing), the rules of R1 and R2 apply unchanged.
- R4: In interrupt or trap context outside extended addressing, the address is always bits 12-31, `wide_o`=1 and `idx_ok_o`=0; with bit 10 at 0 it is real (`mapped_o`=0).
- R5: In interrupt or trap context outside extended addressing with bit 10 at 1, `mapped_o` and `ind_mapped_o` equal `map_bit_i`.
- R6: The index field (bits 12-14) appears on `idx_reg_o` only when indexing is allowed; otherwise `idx_reg_o` is 0.
- R7: When bit 0 is 1, `ind_req_o` is raised in the cycle after start, with `ind_addr_o` = the reference address. It is held until `ind_ack_i`. `done_o` follows in the next cycle, with `ref_addr_o` = `ind_data_i` trimmed to the width class of R1-type or R2-type.
- R8: When bit 0 is 0, `done_o` is high for exactly one cycle, in the cycle after start is sampled, and no indirect request is made.
- R9: After reset, `busy_o`, `done_o` and `ind_req_o` are 0 and all result outputs are 0.
- R10: `start_i` is ignored while `busy_o` is 1; the latched result is unchanged.
- R11: `ind_ok_o` is 1 for every completed selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a selection |
| instr_i | input | 32 | Instruction word |
| ctx_i | input | 2 | 0 ordinary, 1 interrupt, 2 trap |
| ma_i | input | 1 | Mode bit MA |
| mm_i | input | 1 | Mode bit MM |
| map_bit_i | input | 1 | Current status-word mapping bit (bit 9) |
| ind_ack_i | input | 1 | Indirect word is valid |
| ind_data_i | input | 20 | Indirect word, low address bits |
| busy_o | output | 1 | Selection in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ind_req_o | output | 1 | Indirect fetch request |
| ind_addr_o | output | 20 | Address for the indirect fetch |
| ind_mapped_o | output | 1 | Indirect fetch goes through translation |
| ref_addr_o | output | 20 | Final reference address |
| wide_o | output | 1 | 1 = 20-bit class, 0 = 17-bit class |
| idx_ok_o | output | 1 | Indexing allowed |
| ind_ok_o | output | 1 | Indirection allowed |
| mapped_o | output | 1 | Address translated per status words |
| idx_reg_o | output | 3 | Index register number, 0 when not allowed |

## Verification
The case hardest to reach from the ports is a new start arriving while an indirect fetch is still outstanding. Reaching it means holding off the acknowledge for several cycles after the request appears. The bench pulses start with a different instruction during that window, then acknowledges. It checks that the trimmed result and its flags come from the first instruction. A separate indirect run in trap context outside extended addressing confirms that the mapping bit reaches the indirect request and that the 20-bit trim is kept.

// File: rtl/swx_pkg.sv
package swx_pkg;

    typedef enum logic [1:0] {
        CTX_NORMAL = 2'd0,
        CTX_INTR   = 2'd1,
        CTX_TRAP   = 2'd2
    } ctx_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } st_e;

    typedef struct packed {
        logic wide;
        logic idx_ok;
        logic ind_ok;
        logic mapped;
    } cls_t;

endpackage

// File: rtl/swx_fit.sv
module swx_fit #(
    parameter int LONG_W = 20,
    parameter int IDX_W  = 3
) (
    input  logic [LONG_W-1:0] data_i,
    input  logic              wide_i,
    output logic [LONG_W-1:0] data_o
);
    localparam int SHORT_W = LONG_W - IDX_W;

    always_comb begin
        if (wide_i) begin
            data_o = data_i;
        end else begin
            data_o = {{IDX_W{1'b0}}, data_i[SHORT_W-1:0]};
        end
    end
endmodule

// File: rtl/swx_classify.sv
module swx_classify
    import swx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LONG_W = 20,
    parameter int IDX_W  = 3
) (
    input  logic [WORD_W-1:0] instr_i,
    input  logic [1:0]        ctx_i,
    input  logic              ma_i,
    input  logic              mm_i,
    input  logic              map_bit_i,
    output cls_t              cls_o,
    output logic [LONG_W-1:0] addr_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              ind_bit_o
);
    // Bit k counted from the MSB sits at index WORD_W-1-k.
    localparam int IND_POS = WORD_W - 1;
    localparam int AT_POS  = WORD_W - 1 - 10;

    logic at_bit;
    logic ext_mode;
    logic std_rules;
    logic unused_bits;

    assign at_bit      = instr_i[AT_POS];
    assign ind_bit_o   = instr_i[IND_POS];
    assign idx_o       = instr_i[LONG_W-1 -: IDX_W];
    assign ext_mode    = ma_i & ~mm_i;
    assign std_rules   = (ctx_e'(ctx_i) == CTX_NORMAL) | ext_mode;
    assign unused_bits = ^instr_i[IND_POS-1:AT_POS+1] ^ ^instr_i[AT_POS-1:LONG_W];

    always_comb begin
        cls_o.ind_ok = 1'b1;
        if (std_rules) begin
            cls_o.wide   = ~at_bit;
            cls_o.idx_ok = at_bit;
            cls_o.mapped = at_bit;
        end else begin
            cls_o.wide   = 1'b1;
            cls_o.idx_ok = 1'b0;
            cls_o.mapped = at_bit & map_bit_i;
        end
    end

    swx_fit #(.LONG_W(LONG_W), .IDX_W(IDX_W)) u_fit (
        .data_i (instr_i[LONG_W-1:0]),
        .wide_i (cls_o.wide),
        .data_o (addr_o)
    );
endmodule

// File: rtl/swx_seq.sv
module swx_seq
    import swx_pkg::*;
#(
    parameter int LONG_W = 20,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  cls_t              cls_i,
    input  logic [LONG_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              ind_bit_i,
    input  logic              ind_ack_i,
    input  logic [LONG_W-1:0] ind_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ind_req_o,
    output logic [LONG_W-1:0] ind_addr_o,
    output logic              ind_mapped_o,
    output logic [LONG_W-1:0] ref_addr_o,
    output cls_t              cls_o,
    output logic [IDX_W-1:0]  idx_reg_o
);
    typedef struct packed {
        st_e              st;
        logic [LONG_W-1:0] addr;
        cls_t              cls;
        logic [IDX_W-1:0]  idx;
    } state_t;

    state_t            s_d, s_q;
    logic [LONG_W-1:0] ind_fit;

    swx_fit #(.LONG_W(LONG_W), .IDX_W(IDX_W)) u_ind_fit (
        .data_i (ind_data_i),
        .wide_i (s_q.cls.wide),
        .data_o (ind_fit)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.addr = addr_i;
                    s_d.cls  = cls_i;
                    s_d.idx  = cls_i.idx_ok ? idx_i : '0;
                    s_d.st   = ind_bit_i ? ST_FETCH : ST_DONE;
                end
            end
            ST_FETCH: begin
                if (ind_ack_i) begin
                    s_d.addr = ind_fit;
                    s_d.st   = ST_DONE;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.st != ST_IDLE);
    assign done_o       = (s_q.st == ST_DONE);
    assign ind_req_o    = (s_q.st == ST_FETCH);
    assign ind_addr_o   = s_q.addr;
    assign ind_mapped_o = s_q.cls.mapped;
    assign ref_addr_o   = s_q.addr;
    assign cls_o        = s_q.cls;
    assign idx_reg_o    = s_q.idx;
endmodule

// File: rtl/sw_xchg_addr_sel.sv
module sw_xchg_addr_sel
    import swx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LONG_W = 20,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [1:0]        ctx_i,
    input  logic              ma_i,
    input  logic              mm_i,
    input  logic              map_bit_i,
    input  logic              ind_ack_i,
    input  logic [LONG_W-1:0] ind_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ind_req_o,
    output logic [LONG_W-1:0] ind_addr_o,
    output logic              ind_mapped_o,
    output logic [LONG_W-1:0] ref_addr_o,
    output logic              wide_o,
    output logic              idx_ok_o,
    output logic              ind_ok_o,
    output logic              mapped_o,
    output logic [IDX_W-1:0]  idx_reg_o
);
    cls_t              cls_in;
    cls_t              cls_out;
    logic [LONG_W-1:0] addr_in;
    logic [IDX_W-1:0]  idx_in;
    logic              ind_bit;

    swx_classify #(.WORD_W(WORD_W), .LONG_W(LONG_W), .IDX_W(IDX_W)) u_classify (
        .instr_i   (instr_i),
        .ctx_i     (ctx_i),
        .ma_i      (ma_i),
        .mm_i      (mm_i),
        .map_bit_i (map_bit_i),
        .cls_o     (cls_in),
        .addr_o    (addr_in),
        .idx_o     (idx_in),
        .ind_bit_o (ind_bit)
    );

    swx_seq #(.LONG_W(LONG_W), .IDX_W(IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cls_i        (cls_in),
        .addr_i       (addr_in),
        .idx_i        (idx_in),
        .ind_bit_i    (ind_bit),
        .ind_ack_i    (ind_ack_i),
        .ind_data_i   (ind_data_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .ind_req_o    (ind_req_o),
        .ind_addr_o   (ind_addr_o),
        .ind_mapped_o (ind_mapped_o),
        .ref_addr_o   (ref_addr_o),
        .cls_o        (cls_out),
        .idx_reg_o    (idx_reg_o)
    );

    assign wide_o   = cls_out.wide;
    assign idx_ok_o = cls_out.idx_ok;
    assign ind_ok_o = cls_out.ind_ok;
    assign mapped_o = cls_out.mapped;
endmodule

// File: rtl/swx_addr_sel_chk.sv
module swx_addr_sel_chk #(
    parameter int LONG_W = 20,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ind_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              ind_req_o,
    input logic [LONG_W-1:0] ind_addr_o,
    input logic [LONG_W-1:0] ref_addr_o,
    input logic              wide_o,
    input logic              idx_ok_o,
    input logic [IDX_W-1:0]  idx_reg_o
);
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req_o && !ind_ack_i |=> ind_req_o);

    a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req_o && ind_ack_i |=> done_o && !ind_req_o);

    a_r10_ind_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req_o && !ind_ack_i |=> $stable(ind_addr_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o && !ind_req_o);

    a_r6_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_ok_o |-> idx_reg_o == '0);

    a_r2_short_fit: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !wide_o |-> ref_addr_o[LONG_W-1 -: IDX_W] == '0);

    a_r4_wide_no_index: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && wide_o |-> !idx_ok_o);
endmodule

bind sw_xchg_addr_sel swx_addr_sel_chk #(.LONG_W(LONG_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ind_ack_i  (ind_ack_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ind_req_o  (ind_req_o),
    .ind_addr_o (ind_addr_o),
    .ref_addr_o (ref_addr_o),
    .wide_o     (wide_o),
    .idx_ok_o   (idx_ok_o),
    .idx_reg_o  (idx_reg_o)
);

// File: tb/sw_xchg_addr_sel_bench.sv
module sw_xchg_addr_sel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [1:0]  ctx_i = '0;
    logic        ma_i = 1'b0;
    logic        mm_i = 1'b0;
    logic        map_bit_i = 1'b0;
    logic        ind_ack_i = 1'b0;
    logic [19:0] ind_data_i = '0;
    logic        busy_o, done_o, ind_req_o, ind_mapped_o;
    logic [19:0] ind_addr_o, ref_addr_o;
    logic        wide_o, idx_ok_o, ind_ok_o, mapped_o;
    logic [2:0]  idx_reg_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sw_xchg_addr_sel u_sw_xchg_addr_sel (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .instr_i (instr_i),
        .ctx_i (ctx_i), .ma_i (ma_i), .mm_i (mm_i), .map_bit_i (map_bit_i),
        .ind_ack_i (ind_ack_i), .ind_data_i (ind_data_i),
        .busy_o (busy_o), .done_o (done_o), .ind_req_o (ind_req_o),
        .ind_addr_o (ind_addr_o), .ind_mapped_o (ind_mapped_o),
        .ref_addr_o (ref_addr_o), .wide_o (wide_o), .idx_ok_o (idx_ok_o),
        .ind_ok_o (ind_ok_o), .mapped_o (mapped_o), .idx_reg_o (idx_reg_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  ctx;
        logic        ma, mm, mb, at;
        logic [19:0] addr;
        logic        wide, idx, map;
        logic [2:0]  ireg;
    } vec_t;

    localparam logic [19:0] A = 20'hABCDE;
    localparam logic [19:0] S = 20'h0BCDE;

    localparam vec_t VEC [9] = '{
        '{4'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, A, 1'b1, 1'b0, 1'b0, 3'd0}, // R1
        '{4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, S, 1'b0, 1'b1, 1'b1, 3'd5}, // R2
        '{4'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, S, 1'b0, 1'b1, 1'b1, 3'd5}, // R2 modes ignored
        '{4'd3, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, A, 1'b1, 1'b0, 1'b0, 3'd0}, // R3
        '{4'd3, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, S, 1'b0, 1'b1, 1'b1, 3'd5}, // R3
        '{4'd5, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, A, 1'b1, 1'b0, 1'b1, 3'd0}, // R5
        '{4'd5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, A, 1'b1, 1'b0, 1'b0, 3'd0}, // R5
        '{4'd4, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, A, 1'b1, 1'b0, 1'b0, 3'd0}, // R4
        '{4'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, A, 1'b1, 1'b0, 1'b0, 3'd0}  // R4
    };

    function automatic logic [31:0] mk(input logic ind, input logic at, input logic [19:0] a);
        logic [31:0] w;
        w = '0;
        w[31] = ind;
        w[21] = at;
        w[22] = 1'b1;
        w[23] = 1'b1;
        w[19:0] = a;
        return w;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic kick(input logic [31:0] ins, input logic [1:0] c, input logic ma,
                        input logic mm, input logic mb);
        instr_i = ins; ctx_i = c; ma_i = ma; mm_i = mm; map_bit_i = mb;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", "busy", busy_o, 0);
        check("R9", "done", done_o, 0);
        check("R9", "ind_req", ind_req_o, 0);
        check("R9", "ref_addr", ref_addr_o, 0);
        check("R9", "flags", {wide_o, idx_ok_o, ind_ok_o, mapped_o, idx_reg_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            kick(mk(1'b0, VEC[i].at, A), VEC[i].ctx, VEC[i].ma, VEC[i].mm, VEC[i].mb);
            check($sformatf("R%0d", VEC[i].req), "addr", ref_addr_o, VEC[i].addr);
            check($sformatf("R%0d", VEC[i].req), "wide", wide_o, VEC[i].wide);
            check($sformatf("R%0d", VEC[i].req), "idx_ok", idx_ok_o, VEC[i].idx);
            check($sformatf("R%0d", VEC[i].req), "mapped", mapped_o, VEC[i].map);
            check("R6", "idx_reg", idx_reg_o, VEC[i].ireg);
            check("R11", "ind_ok", ind_ok_o, 1);
            check("R8", "done", done_o, 1);
            check("R8", "no ind_req", ind_req_o, 0);
            @(negedge clk);
            check("R8", "done drop", done_o, 0);
        end

        // R7 indirect in ordinary context, AT=1, with R10 start while busy
        kick(mk(1'b1, 1'b1, A), 2'd0, 1'b0, 1'b0, 1'b0);
        check("R7", "ind_req", ind_req_o, 1);
        check("R7", "ind_addr", ind_addr_o, S);
        check("R7", "ind_mapped", ind_mapped_o, 1);
        check("R7", "no done", done_o, 0);
        kick(mk(1'b0, 1'b0, 20'h11111), 2'd1, 1'b0, 1'b0, 1'b1);
        check("R10", "ind_req held", ind_req_o, 1);
        check("R10", "ind_addr held", ind_addr_o, S);
        @(negedge clk);
        ind_data_i = 20'h45678;
        ind_ack_i = 1'b1;
        @(negedge clk);
        ind_ack_i = 1'b0;
        check("R7", "done", done_o, 1);
        check("R7", "ref trimmed", ref_addr_o, 20'h05678);
        check("R10", "wide kept", wide_o, 0);
        check("R10", "idx_reg kept", idx_reg_o, 5);
        check("R7", "req off", ind_req_o, 0);
        @(negedge clk);

        // R5 indirect, trap outside extended mode, AT=1, mapping bit set
        kick(mk(1'b1, 1'b1, A), 2'd2, 1'b1, 1'b1, 1'b1);
        check("R5", "ind_mapped", ind_mapped_o, 1);
        check("R5", "ind_addr", ind_addr_o, A);
        ind_data_i = 20'hF4321;
        ind_ack_i = 1'b1;
        @(negedge clk);
        ind_ack_i = 1'b0;
        check("R5", "ref wide", ref_addr_o, 20'hF4321);
        check("R4", "no index", idx_ok_o, 0);
        @(negedge clk);

        // R5 same path with mapping bit clear
        kick(mk(1'b1, 1'b1, A), 2'd1, 1'b0, 1'b0, 1'b0);
        check("R5", "ind_mapped clear", ind_mapped_o, 0);
        ind_ack_i = 1'b1;
        @(negedge clk);
        ind_ack_i = 1'b0;
        check("R5", "mapped clear", mapped_o, 0);
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule